// File: doc/BRIEF.md
# Flash Line Buffer with Sequential Prefetch

This block sits between a processor's code-space port and a slow flash array whose natural read unit is a 128-bit line. It keeps eight recently used or prefetched lines. Requests carry a byte address and a flag that tells an instruction fetch from a data read. A request whose line is buffered gets a 32-bit word back one clock later. The word starts at any 16-bit boundary, so a mix of 16-bit and 32-bit instructions can be served. A request whose line is not buffered starts a full-line read on the flash port and then waits until that line arrives.

Each entry is marked as instruction or data when it is filled, and it carries a recency rank. An instruction hit also starts a read of the next sequential line when that line is missing and the flash port is free. Sequential code therefore finds its next line already waiting. When a line must be evicted, the victim is drawn first from lines of the other kind, so a branch back into recently run code tends to find it still resident. A one-cycle invalidate empties the whole array.

Top module: `flash_line_buf`

## Requirements
- R1: While reset is held, and in the first cycle after it, `resp_valid_o` and `fl_req_o` are low. After reset every entry is empty, so the first request to any line starts a flash read.
- R2: Byte address bits [3:1] choose a halfword h inside the line, and bit 0 is ignored. The response word holds halfword h in bits [15:0] and halfword h+1 in bits [31:16]. Halfword k occupies bits [16k+15:16k] of the line. When h is 7, bits [31:16] are zero.
- R3: A hit raises `resp_valid_o` for exactly one cycle, in the cycle after the clock edge that sees the request, and it starts no flash read of its own. A miss raises `fl_req_o` for one cycle, one cycle after the edge that sees it, with `fl_line_o` equal to address bits [ADDR_W-1:4]. The request is answered once the line has returned.
- R4: An instruction hit, while no flash read is outstanding, starts a read of the next line (line + 1) in the same cycle as its response, unless that line is already buffered.
- R5: A request for a line whose read is still in flight waits for that read and does not issue a second read of the same line.
- R6: Among candidates of equal preference, the least recently accessed entry is evicted. Both a hit and a completed fill count as an access.
- R7: An empty entry is always used first. Otherwise a data fill evicts an instruction-marked entry before any data-marked one, and an instruction fill (miss or prefetch) evicts a data-marked entry first. The mark is set when the line is filled and is not changed by later hits.
- R8: A one-cycle pulse on `inv_i` empties every entry, and a line still in flight at that time is discarded when it arrives. No request is accepted in the invalidate cycle.
- R9: At most one flash read is outstanding: `fl_req_o` does not rise again until `fl_rvalid_i` has returned the previous line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_i | input | 1 | Empty all entries this cycle |
| req_valid_i | input | 1 | Request present; held until the response |
| req_addr_i | input | ADDR_W (32) | Byte address of the request |
| req_instr_i | input | 1 | 1 = instruction fetch, 0 = data read |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_data_o | output | 32 | Selected word |
| fl_req_o | output | 1 | One-cycle line read request to flash |
| fl_line_o | output | ADDR_W-4 (28) | Line address of the read |
| fl_rvalid_i | input | 1 | Requested line is present on `fl_rdata_i` |
| fl_rdata_i | input | 128 | Returned line |

## Verification
A hit is due on `resp_valid_o` one clock after the edge that samples the request. A miss is answered one clock after the edge that writes the returned line, because the request is still held and is accepted on the next edge. A flash read appears on `fl_req_o` one clock after the edge that starts it, so a prefetch lines up with the response of the hit that caused it. The bench changes inputs and reads outputs on the falling edge and waits for the response strobe, so every sample lands in the cycle after the edge that produced it. Its flash model counts reads per line, which shows which lines stayed resident and which were evicted.

// File: rtl/fb_pkg.sv
package fb_pkg;
    localparam int LINE_W      = 128;
    localparam int WORD_W      = 32;
    localparam int HALF_W      = 16;
    localparam int HW_PER_LINE = LINE_W / HALF_W;
    localparam int OFS_W       = $clog2(LINE_W / 8);
    localparam int HSEL_W      = $clog2(HW_PER_LINE);

    typedef enum logic {
        KIND_DATA  = 1'b0,
        KIND_INSTR = 1'b1
    } kind_e;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic busy;
        logic drop;
    } fill_t;
endpackage

// File: rtl/fb_word_sel.sv
module fb_word_sel
    import fb_pkg::*;
(
    input  line_t             line_i,
    input  logic [HSEL_W-1:0] hsel_i,
    output word_t             word_o
);
    // A logical right shift pulls zeros in above the last halfword.
    always_comb begin
        word_o = WORD_W'(line_i >> (32'(hsel_i) * HALF_W));
    end
endmodule

// File: rtl/fb_store.sv
module fb_store
    import fb_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int TAG_W = 28,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inv_i,
    input  logic             alloc_i,
    input  logic [IDX_W-1:0] alloc_idx_i,
    input  logic [TAG_W-1:0] alloc_tag_i,
    input  logic             alloc_kind_i,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  line_t            wr_line_i,
    input  logic [TAG_W-1:0] look_tag_i,
    input  logic [TAG_W-1:0] next_tag_i,
    output logic [N_ENT-1:0] valid_o,
    output logic [N_ENT-1:0] kind_o,
    output logic [N_ENT-1:0] hit_vec_o,
    output logic             next_hit_o,
    output line_t            hit_line_o
);
    logic [TAG_W-1:0] tag_q [N_ENT];
    line_t            data_q [N_ENT];
    logic [N_ENT-1:0] valid_q;
    logic [N_ENT-1:0] kind_q;
    logic [N_ENT-1:0] next_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (inv_i) begin
            valid_q <= '0;
        end else begin
            if (alloc_i) valid_q[alloc_idx_i] <= 1'b0;
            if (wr_i)    valid_q[wr_idx_i]    <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= '0;
        end else if (alloc_i) begin
            kind_q[alloc_idx_i] <= alloc_kind_i;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_i) tag_q[alloc_idx_i] <= alloc_tag_i;
        if (wr_i)    data_q[wr_idx_i]   <= wr_line_i;
    end

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        assign hit_vec_o[e] = valid_q[e] && (tag_q[e] == look_tag_i);
        assign next_vec[e]  = valid_q[e] && (tag_q[e] == next_tag_i);
    end

    always_comb begin
        hit_line_o = '0;
        for (int e = 0; e < N_ENT; e++) begin
            hit_line_o = hit_line_o | (data_q[e] & {LINE_W{hit_vec_o[e]}});
        end
    end

    assign next_hit_o = |next_vec;
    assign valid_o    = valid_q;
    assign kind_o     = kind_q;

    // R8
    inv_clear_chk: assert property (@(posedge clk) disable iff (rst)
        inv_i |=> (valid_q == '0));

    // R3
    hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec_o));
endmodule

// File: rtl/fb_lru.sv
module fb_lru #(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int RANKS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_a_i,
    input  logic [IDX_W-1:0] idx_a_i,
    input  logic             touch_b_i,
    input  logic [IDX_W-1:0] idx_b_i,
    input  logic [N_ENT-1:0] valid_i,
    input  logic [N_ENT-1:0] kind_i,
    input  logic             want_kind_i,
    input  logic [N_ENT-1:0] excl_i,
    output logic [IDX_W-1:0] victim_o
);
    // Rank 0 = most recent; ranks stay a permutation of entry indices.
    logic [IDX_W-1:0] age_q [N_ENT];
    logic [IDX_W-1:0] age_a [N_ENT];
    logic [IDX_W-1:0] age_b [N_ENT];

    always_comb begin
        for (int i = 0; i < N_ENT; i++) age_a[i] = age_q[i];
        if (touch_a_i) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (IDX_W'(i) == idx_a_i)              age_a[i] = '0;
                else if (age_q[i] < age_q[idx_a_i])    age_a[i] = age_q[i] + 1'b1;
            end
        end
        for (int i = 0; i < N_ENT; i++) age_b[i] = age_a[i];
        if (touch_b_i) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (IDX_W'(i) == idx_b_i)              age_b[i] = '0;
                else if (age_a[i] < age_a[idx_b_i])    age_b[i] = age_a[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENT; i++) begin
            if (rst) age_q[i] <= IDX_W'(i);
            else     age_q[i] <= age_b[i];
        end
    end

    logic             have_free, have_other, have_any;
    logic [IDX_W-1:0] free_idx, other_idx, any_idx;
    logic [IDX_W-1:0] other_age, any_age;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!valid_i[i] && !excl_i[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
        have_other = 1'b0; other_idx = '0; other_age = '0;
        have_any   = 1'b0; any_idx   = '0; any_age   = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!excl_i[i]) begin
                if (!have_any || age_q[i] > any_age) begin
                    have_any = 1'b1; any_idx = IDX_W'(i); any_age = age_q[i];
                end
                if ((kind_i[i] != want_kind_i) && (!have_other || age_q[i] > other_age)) begin
                    have_other = 1'b1; other_idx = IDX_W'(i); other_age = age_q[i];
                end
            end
        end
        if (have_free)       victim_o = free_idx;
        else if (have_other) victim_o = other_idx;
        else                 victim_o = any_idx;
    end

    logic [RANKS-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < N_ENT; i++) seen[age_q[i]] = 1'b1;
    end

    // R6
    age_perm_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(seen) == N_ENT);

    // R7
    victim_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !excl_i[victim_o]);
endmodule

// File: rtl/flash_line_buf.sv
module flash_line_buf
    import fb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_ENT  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    inv_i,
    input  logic                    req_valid_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic                    req_instr_i,
    output logic                    resp_valid_o,
    output logic [WORD_W-1:0]       resp_data_o,
    output logic                    fl_req_o,
    output logic [ADDR_W-OFS_W-1:0] fl_line_o,
    input  logic                    fl_rvalid_i,
    input  logic [LINE_W-1:0]       fl_rdata_i
);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam int IDX_W = $clog2(N_ENT);

    logic [TAG_W-1:0]  req_tag, next_tag, start_tag;
    logic [HSEL_W-1:0] hsel;
    logic              addr_lsb_unused;
    logic [N_ENT-1:0]  hit_vec, valid_vec, kind_vec;
    logic              hit_any, next_hit;
    line_t             hit_line;
    word_t             sel_word;
    logic [IDX_W-1:0]  hit_idx, victim, fill_idx;
    fill_t             fill_q;
    logic              accept, miss_go, pf_go, start, fill_done, fill_wr;
    kind_e             start_kind;

    assign req_tag         = req_addr_i[ADDR_W-1:OFS_W];
    assign next_tag        = req_tag + TAG_W'(1);
    assign hsel            = req_addr_i[OFS_W-1:1];
    assign addr_lsb_unused = req_addr_i[0];

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit_any    = |hit_vec;
    assign accept     = req_valid_i && hit_any && !inv_i;
    assign miss_go    = req_valid_i && !hit_any && !fill_q.busy && !inv_i;
    assign pf_go      = accept && req_instr_i && !next_hit && !fill_q.busy;
    assign start      = miss_go || pf_go;
    assign start_tag  = miss_go ? req_tag : next_tag;
    assign start_kind = (miss_go && !req_instr_i) ? KIND_DATA : KIND_INSTR;
    assign fill_done  = fl_rvalid_i && fill_q.busy;
    assign fill_wr    = fill_done && !fill_q.drop && !inv_i;

    fb_store #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .inv_i        (inv_i),
        .alloc_i      (start),
        .alloc_idx_i  (victim),
        .alloc_tag_i  (start_tag),
        .alloc_kind_i (start_kind),
        .wr_i         (fill_wr),
        .wr_idx_i     (fill_idx),
        .wr_line_i    (fl_rdata_i),
        .look_tag_i   (req_tag),
        .next_tag_i   (next_tag),
        .valid_o      (valid_vec),
        .kind_o       (kind_vec),
        .hit_vec_o    (hit_vec),
        .next_hit_o   (next_hit),
        .hit_line_o   (hit_line)
    );

    fb_lru #(.N_ENT(N_ENT)) u_lru (
        .clk         (clk),
        .rst         (rst),
        .touch_a_i   (fill_wr),
        .idx_a_i     (fill_idx),
        .touch_b_i   (accept),
        .idx_b_i     (hit_idx),
        .valid_i     (valid_vec),
        .kind_i      (kind_vec),
        .want_kind_i (start_kind),
        .excl_i      (hit_vec),
        .victim_o    (victim)
    );

    fb_word_sel u_sel (
        .line_i (hit_line),
        .hsel_i (hsel),
        .word_o (sel_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q   <= '{busy: 1'b0, drop: 1'b0};
            fill_idx <= '0;
        end else begin
            if (start) begin
                fill_q.busy <= 1'b1;
                fill_q.drop <= 1'b0;
                fill_idx    <= victim;
            end else if (fill_done) begin
                fill_q.busy <= 1'b0;
            end
            if (inv_i && fill_q.busy && !fill_done) fill_q.drop <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid_o <= 1'b0;
            resp_data_o  <= '0;
            fl_req_o     <= 1'b0;
            fl_line_o    <= '0;
        end else begin
            resp_valid_o <= accept;
            if (accept) resp_data_o <= sel_word;
            fl_req_o     <= start;
            if (start) fl_line_o <= start_tag;
        end
    end

    // Port-level record of an outstanding flash read.
    logic rd_pend_q;
    always_ff @(posedge clk) begin
        if (rst) rd_pend_q <= 1'b0;
        else     rd_pend_q <= (rd_pend_q && !fl_rvalid_i) || fl_req_o;
    end

    // R9
    one_read_chk: assert property (@(posedge clk) disable iff (rst)
        fl_req_o |-> !rd_pend_q);

    // R3
    resp_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid_o |-> $past(req_valid_i));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!resp_valid_o && !fl_req_o));

    // R8
    inv_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $past(inv_i) |-> !resp_valid_o);
endmodule

// File: tb/tb_flash_line_buf.sv
module tb_flash_line_buf;
    import fb_pkg::*;

    localparam int ADDR_W = 32;
    localparam int TAG_W  = ADDR_W - OFS_W;

    logic              clk = 1'b0;
    logic              rst, inv, req_valid, req_instr;
    logic [ADDR_W-1:0] req_addr;
    logic              resp_valid, fl_req, fl_rvalid;
    logic [31:0]       resp_data;
    logic [TAG_W-1:0]  fl_line;
    logic [127:0]      fl_rdata;

    always #5 clk = ~clk;

    flash_line_buf #(.ADDR_W(ADDR_W), .N_ENT(8)) dut (
        .clk(clk), .rst(rst), .inv_i(inv),
        .req_valid_i(req_valid), .req_addr_i(req_addr), .req_instr_i(req_instr),
        .resp_valid_o(resp_valid), .resp_data_o(resp_data),
        .fl_req_o(fl_req), .fl_line_o(fl_line),
        .fl_rvalid_i(fl_rvalid), .fl_rdata_i(fl_rdata)
    );

    int n_chk = 0, n_bad = 0;
    int lat = 2;
    int reads = 0, dup_reads = 0;
    int line_reads [256];
    logic [TAG_W-1:0] last_line;
    bit done = 0;

    function automatic logic [15:0] hw_of(logic [TAG_W-1:0] ln, int k);
        logic [31:0] v;
        v = (32'(ln) * 8 + 32'(k)) * 32'h9E37 + 32'h1234;
        return v[23:8];
    endfunction

    function automatic logic [127:0] line_of(logic [TAG_W-1:0] ln);
        logic [127:0] l;
        for (int k = 0; k < 8; k++) l[k*16 +: 16] = hw_of(ln, k);
        return l;
    endfunction

    function automatic logic [31:0] exp_word(logic [31:0] a);
        int h;
        logic [15:0] hi;
        h  = int'(a[3:1]);
        hi = (h == 7) ? 16'h0 : hw_of(a[31:4], h + 1);
        return {hi, hw_of(a[31:4], h)};
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Flash model: one line per read, returned lat falling edges later.
    int cnt = -1;
    logic [TAG_W-1:0] pend;
    always @(negedge clk) begin
        fl_rvalid = 1'b0;
        if (cnt > 0) cnt--;
        if (cnt == 0) begin
            fl_rvalid = 1'b1;
            fl_rdata  = line_of(pend);
            cnt = -1;
        end
        if (fl_req) begin
            if (cnt >= 0) dup_reads++;
            pend = fl_line;
            last_line = fl_line;
            cnt = lat;
            reads++;
            line_reads[int'(fl_line[7:0])]++;
        end
    end

    task automatic do_req(input logic [31:0] a, input logic ins, input int idle,
                          output logic [31:0] d);
        int w = 0;
        req_addr = a; req_instr = ins; req_valid = 1'b1;
        do begin
            @(negedge clk);
            w++;
        end while (!resp_valid && w < 100);
        req_valid = 1'b0;
        d = resp_data;
        if (w >= 100) begin
            n_chk++; n_bad++;
            $display("FAIL R3 no response actual=timeout expected=resp for %h", a);
        end
        repeat (idle) @(negedge clk);
    endtask

    task automatic do_inv();
        inv = 1'b1;
        @(negedge clk);
        inv = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d, a;
        int r0, c0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) line_reads[i] = 0;
        rst = 1'b1; inv = 1'b0; req_valid = 1'b0; req_instr = 1'b0;
        req_addr = '0; fl_rvalid = 1'b0; fl_rdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 resp_valid in reset", 32'(resp_valid), 32'd0);
        chk("R1 fl_req in reset", 32'(fl_req), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 resp_valid after reset", 32'(resp_valid), 32'd0);

        // R1/R3: first access misses, reads the right line
        r0 = reads;
        do_req(32'h100, 1'b0, 8, d);
        chk("R1 first access reads", 32'(reads - r0), 32'd1);
        chk("R3 miss line address", 32'(last_line), 32'h10);
        chk("R3 miss data", d, exp_word(32'h100));
        r0 = reads;
        do_req(32'h104, 1'b0, 8, d);
        chk("R3 hit makes no read", 32'(reads - r0), 32'd0);

        // R2: every halfword offset, bit 0 ignored
        for (int h = 0; h < 8; h++) begin
            a = 32'h100 | 32'(h * 2) | 32'(h & 1);
            do_req(a, 1'b0, 1, d);
            chk("R2 halfword select", d, exp_word(a));
        end

        // R4: instruction hit prefetches next line
        do_inv();
        r0 = reads;
        do_req(32'h300, 1'b1, 8, d);
        chk("R4 miss plus prefetch reads", 32'(reads - r0), 32'd2);
        chk("R4 prefetch line", 32'(last_line), 32'h31);
        do_req(32'h316, 1'b1, 8, d);
        chk("R4 prefetched line hits", 32'(line_reads[8'h31]), 32'd1);
        chk("R4 data", d, exp_word(32'h316));

        // R5: request to a line in flight waits, single read
        do_inv();
        lat = 4;
        do_req(32'h400, 1'b1, 0, d);
        do_req(32'h410, 1'b1, 8, d);
        chk("R5 single read of in-flight line", 32'(line_reads[8'h41]), 32'd1);
        chk("R5 data after wait", d, exp_word(32'h410));

        // R8: invalidate forces a re-read
        lat = 2;
        c0 = line_reads[8'h40];
        do_inv();
        do_req(32'h400, 1'b0, 8, d);
        chk("R8 re-read after invalidate", 32'(line_reads[8'h40] - c0), 32'd1);
        chk("R8 data", d, exp_word(32'h400));

        // R6: pure LRU among data entries
        do_inv();
        for (int l = 0; l < 8; l++) do_req(32'h500 + 32'(l * 16), 1'b0, 6, d);
        do_req(32'h500, 1'b0, 6, d);
        do_req(32'h580, 1'b0, 6, d);
        do_req(32'h504, 1'b0, 6, d);
        chk("R6 recently used line kept", 32'(line_reads[8'h50]), 32'd1);
        do_req(32'h510, 1'b0, 6, d);
        chk("R6 least recent line evicted", 32'(line_reads[8'h51]), 32'd2);

        // R7: data fill evicts instruction-marked entry first
        do_inv();
        for (int i = 0; i < 256; i++) line_reads[i] = 0;
        do_req(32'h600, 1'b1, 8, d);
        for (int l = 0; l < 6; l++) do_req(32'h700 + 32'(l * 16), 1'b0, 6, d);
        do_req(32'h600, 1'b0, 6, d);
        do_req(32'h610, 1'b0, 6, d);
        do_req(32'h760, 1'b0, 6, d);
        do_req(32'h700, 1'b0, 6, d);
        chk("R7 old data line kept", 32'(line_reads[8'h70]), 32'd1);
        do_req(32'h600, 1'b0, 6, d);
        chk("R7 instruction line evicted", 32'(line_reads[8'h60]), 32'd2);
        chk("R7 data", d, exp_word(32'h600));

        // Random mix
        for (int t = 0; t < 400; t++) begin
            lat = int'($urandom_range(1, 4));
            if ($urandom_range(0, 19) == 0) do_inv();
            a = (32'($urandom_range(0, 15)) << 4) | 32'($urandom_range(0, 15));
            do_req(a, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), d);
            chk("R2/R3 random word", d, exp_word(a));
        end
        repeat (8) @(negedge clk);
        chk("R9 no read while one outstanding", 32'(dup_reads), 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule